// File: doc/BRIEF.md
# Byte ALU with Multi-Meaning Parity/Overflow Flag

This block is the arithmetic and logic stage of an 8-bit datapath. It takes two operand bytes, a carry input and an operation code, and produces a result byte and a flag byte in the same cycle. The flag byte holds sign, zero, half-carry, parity/overflow, subtract and carry bits. A copy of the flag byte is captured in a flag register on each clock edge where the enable is high.

One bit of the flag byte changes meaning with the operation. For arithmetic it reports two's-complement overflow. For logic, rotate and input operations it reports even parity of the byte. For block copy and search it reports whether the byte counter is still nonzero. For the interrupt-state load it carries the interrupt-enable bit. The three flag-only modes pass operand `a` through as the result. Decimal adjust, register storage and instruction decode are handled elsewhere.

Top module: `alu8_pv`

## Requirements
- R1: The flag byte is {S, Z, 0, H, 0, PV, N, C}, from bit 7 down to bit 0. S is bit 7 of the result and Z is 1 exactly when the result is zero. Bits 5 and 3 are always 0.
- R2: ADD (op 0) and ADC (op 1) give res = a + b + k, where k = cin for ADC and k = 0 for ADD, so ADD ignores cin. C is the carry out of bit 7, H is the carry from bit 3 into bit 4, and N = 0.
- R3: SUB (op 2) and SBC (op 3) give res = a - b - k, where k = cin for SBC and k = 0 for SUB. C is 1 on a borrow out of bit 7, H is 1 on a borrow from bit 4, and N = 1.
- R4: For ops 0 to 3, PV is 1 exactly when the true signed result lies outside -128..127. Subtraction of like-signed operands and addition of unlike-signed operands never set PV.
- R5: AND (op 4), OR (op 5) and XOR (op 6) set PV to 1 when the result has an even number of 1 bits. They clear C and N. H is 1 for AND and 0 for OR and XOR.
- R6: Rotate left through carry (op 7) gives res = {a[6:0], cin} and C = a[7]. Rotate right through carry (op 8) gives res = {cin, a[7:1]} and C = a[0]. For both, PV is even parity of res, H = N = 0, and b is ignored.
- R7: Block mode (op 9) sets PV = 1 when cnt_zero is 0 and PV = 0 when cnt_zero is 1.
- R8: Interrupt-state load (op 10) sets PV equal to ie_bit.
- R9: Input mode (op 11) sets PV to the even parity of a.
- R10: In ops 9, 10 and 11 the result is a, C equals cin, and H and N are 0.
- R11: flags_q is 0 while rst_n is low. It loads the combinational flag byte on a rising clock edge when en is 1, and holds its value when en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low reset of the flag register |
| en | input | 1 | Flag register load enable |
| op | input | 4 | Operation code (0 to 11) |
| a | input | 8 | First operand; the input byte in mode 11 |
| b | input | 8 | Second operand |
| cin | input | 1 | Carry or borrow in |
| cnt_zero | input | 1 | Decremented byte counter has reached zero |
| ie_bit | input | 1 | Interrupt-enable state to copy |
| res | output | 8 | Result byte |
| flags | output | 8 | Combinational flag byte |
| flags_q | output | 8 | Registered flag byte |

## Verification
The bench sweeps every operand pair with both carry values through all arithmetic, logic and rotate codes. It compares against a reference that computes overflow from the signed range instead of from bit carries. A design that compared the wrong carries would fail at the boundaries where 0x7F and 0x80 meet. A design that let cin leak into ADD or SUB, or that placed the half-carry at the wrong nibble, would miss on a large share of pairs. The flag-only modes are swept over every byte with every cnt_zero, ie_bit and cin combination, which catches an inverted counter sense or odd-parity encoding. Register checks confirm that a load happens only when en is high and that the held value survives a change of inputs.

// File: rtl/alu8_pv.sv
module alu8_pv #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         cnt_zero,
  input  logic         ie_bit,
  output logic [W-1:0] res,
  output logic [7:0]   flags,
  output logic [7:0]   flags_q
);
  localparam int MSB = W - 1;
  localparam int NIB = W / 2;

  localparam logic [3:0] OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBC = 4'd3;
  localparam logic [3:0] OP_AND = 4'd4, OP_OR  = 4'd5, OP_XOR = 4'd6;
  localparam logic [3:0] OP_RL  = 4'd7, OP_RR  = 4'd8;
  localparam logic [3:0] OP_BLK = 4'd9, OP_LDI = 4'd10, OP_INP = 4'd11;

  logic         is_sub, cbit;
  logic [W:0]   wide;
  logic [W-1:0] mid;
  logic [NIB:0] lo;
  logic         h, pv, n, c;

  assign is_sub = (op == OP_SUB) || (op == OP_SBC);
  assign cbit   = ((op == OP_ADC) || (op == OP_SBC)) & cin;

  always_comb begin
    if (is_sub) begin
      wide = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cbit};
      mid  = {1'b0, a[MSB-1:0]} - {1'b0, b[MSB-1:0]} - {{(W-1){1'b0}}, cbit};
      lo   = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - {{NIB{1'b0}}, cbit};
    end else begin
      wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cbit};
      mid  = {1'b0, a[MSB-1:0]} + {1'b0, b[MSB-1:0]} + {{(W-1){1'b0}}, cbit};
      lo   = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cbit};
    end
  end

  always_comb begin
    res = a;
    h   = 1'b0;
    n   = 1'b0;
    c   = 1'b0;
    pv  = 1'b0;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        res = wide[W-1:0];
        c   = wide[W];
        h   = lo[NIB];
        n   = is_sub;
        pv  = mid[MSB] ^ wide[W];
      end
      OP_AND, OP_OR, OP_XOR: begin
        res = (op == OP_AND) ? (a & b) : (op == OP_OR) ? (a | b) : (a ^ b);
        h   = (op == OP_AND);
        pv  = ~^res;
      end
      OP_RL: begin
        res = {a[MSB-1:0], cin};
        c   = a[MSB];
        pv  = ~^res;
      end
      OP_RR: begin
        res = {cin, a[MSB:1]};
        c   = a[0];
        pv  = ~^res;
      end
      OP_BLK: begin c = cin; pv = ~cnt_zero; end
      OP_LDI: begin c = cin; pv = ie_bit;    end
      OP_INP: begin c = cin; pv = ~^a;       end
      default: ;
    endcase
  end

  assign flags = (op > OP_INP) ? 8'h00 : {res[MSB], ~|res, 1'b0, h, 1'b0, pv, n, c};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  flags_q <= 8'h00;
    else if (en) flags_q <= flags;
  end

  p_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> flags_q == $past(flags));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(flags_q));
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sub && (a[MSB] == b[MSB])) |-> !flags[2]);
  p_add_unlike_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_ADD || op == OP_ADC) && (a[MSB] != b[MSB])) |-> !flags[2]);
  p_logic_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_AND || op == OP_OR || op == OP_XOR) |-> (flags[0] == 1'b0 && flags[1] == 1'b0));
  p_rot_hn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RL || op == OP_RR) |-> (flags[4] == 1'b0 && flags[1] == 1'b0));
  p_blk_pv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_BLK) |-> (flags[2] != cnt_zero));
  p_spare_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[5] == 1'b0 && flags[3] == 1'b0));
endmodule

// File: tb/alu8_pv_tb.sv
`timescale 1ns/10ps
module alu8_pv_tb;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] a = 8'd0, b = 8'd0;
  logic cin = 1'b0, cnt_zero = 1'b0, ie_bit = 1'b0;
  logic [7:0] res, flags, flags_q;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  alu8_pv u_dut (.clk(clk), .rst_n(rst_n), .en(en), .op(op), .a(a), .b(b), .cin(cin),
                 .cnt_zero(cnt_zero), .ie_bit(ie_bit), .res(res), .flags(flags), .flags_q(flags_q));

  function automatic logic even_par(input logic [7:0] x);
    int k = 0;
    for (int i = 0; i < 8; i++) k += x[i];
    return (k % 2) == 0;
  endfunction

  function automatic int sgn(input logic [7:0] x);
    return (x > 127) ? int'(x) - 256 : int'(x);
  endfunction

  function automatic logic [15:0] ref_model(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y,
                                            input logic ci, input logic cz, input logic ie);
    logic [7:0] r;
    logic h, p, nn, cc;
    int k, full, sres;
    r = x; h = 0; p = 0; nn = 0; cc = 0;
    k = ((o == 1) || (o == 3)) ? int'(ci) : 0;
    case (o)
      0, 1: begin
        full = int'(x) + int'(y) + k; r = full[7:0]; cc = full > 255;
        h = (int'(x % 16) + int'(y % 16) + k) > 15;
        sres = sgn(x) + sgn(y) + k; p = (sres > 127) || (sres < -128);
      end
      2, 3: begin
        full = int'(x) - int'(y) - k; r = full[7:0]; cc = full < 0; nn = 1;
        h = (int'(x % 16) - int'(y % 16) - k) < 0;
        sres = sgn(x) - sgn(y) - k; p = (sres > 127) || (sres < -128);
      end
      4: begin r = x & y; h = 1; p = even_par(r); end
      5: begin r = x | y; p = even_par(r); end
      6: begin r = x ^ y; p = even_par(r); end
      7: begin r = {x[6:0], ci}; cc = x[7]; p = even_par(r); end
      8: begin r = {ci, x[7:1]}; cc = x[0]; p = even_par(r); end
      9:  begin cc = ci; p = !cz; end
      10: begin cc = ci; p = ie; end
      11: begin cc = ci; p = even_par(x); end
      default: ;
    endcase
    return {r, r[7], (r == 0), 1'b0, h, 1'b0, p, nn, cc};
  endfunction

  function automatic string tag(input logic [3:0] o);
    case (o)
      0, 1: return "R2 R4 R1";
      2, 3: return "R3 R4 R1";
      4, 5, 6: return "R5 R1";
      7, 8: return "R6 R1";
      9: return "R7 R10";
      10: return "R8 R10";
      default: return "R9 R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%02h b=%02h cin=%0b: got %04h expected %04h", req, op, a, b, cin, got, exp);
    end
  endtask

  initial begin
    #(4.0 * 190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (2) @(negedge clk);
    check("R11 reset", {8'h00, flags_q}, 16'h0000);
    rst_n = 1'b1;
    // Arithmetic, logic, rotates: every operand pair, both carry values
    for (int o = 0; o <= 8; o++)
      for (int ci = 0; ci < 2; ci++)
        for (int x = 0; x < 256; x++)
          for (int y = 0; y < 256; y++) begin
            op = 4'(o); cin = ci[0]; a = 8'(x); b = 8'(y);
            #0.1;
            check(tag(op), {res, flags}, ref_model(op, a, b, cin, cnt_zero, ie_bit));
          end
    // R11: en was low throughout the sweep
    @(negedge clk);
    check("R11 hold after sweep", {8'h00, flags_q}, 16'h0000);
    // Flag-only modes
    b = 8'h5A;
    for (int o = 9; o <= 11; o++)
      for (int m = 0; m < 8; m++)
        for (int x = 0; x < 256; x++) begin
          op = 4'(o); cin = m[0]; cnt_zero = m[1]; ie_bit = m[2]; a = 8'(x);
          #0.1;
          check(tag(op), {res, flags}, ref_model(op, a, b, cin, cnt_zero, ie_bit));
        end
    // R11: load on enable, then hold
    @(negedge clk);
    op = 4'd4; a = 8'h00; b = 8'h00; cin = 1'b0; en = 1'b1;
    @(negedge clk);
    en = 1'b0;
    check("R11 load", {8'h00, flags_q}, 16'h0054);
    op = 4'd0; a = 8'h7F; b = 8'h01;
    @(negedge clk);
    check("R11 hold", {8'h00, flags_q}, 16'h0054);
    held = ref_model(4'd0, 8'h7F, 8'h01, 1'b0, 1'b0, 1'b0);
    en = 1'b1;
    @(negedge clk);
    en = 1'b0;
    check("R11 R4 load overflow", {8'h00, flags_q}, {8'h00, held});
    check("R4 0x7F+1 sets PV", {15'h0, flags_q[2]}, 16'h0001);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule